// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounced Key Entry Window

This block sweeps a key matrix of up to 16 rows by 8 columns. Each row line is driven high in turn, and the column lines are read back as active-high pressed levels. It runs from a slow scan clock. Every sweep starts with a fixed lead-in of 5 cycles. Each row then holds for 16 cycles plus the programmed debounce count. An optional idle gap of a programmed length follows the last row, and then the sweep begins again.

Each key keeps a history of consecutive pressed scans. A key counts as held only when its history reaches the debounce count. At the end of each sweep, the held keys replace the contents of an eight-byte entry window, in scan order. Each byte carries a valid flag, the row and the column. Software reads the window through two 32-bit registers. Two sticky interrupt sources are provided, each cleared by writing one to it. The window source fires when a sweep ends with at least the threshold number of entries. The raw keypress source fires as soon as an unmasked column reads pressed on any row, and serves as a wake-up signal. Every row has its own column mask for that source.

Register access uses word addresses: 0 control, 1 interrupt, 2 entries 0 to 3, 3 entries 4 to 7, 4 idle gap, 16+r column mask of row r. Read data appears on `reg_rdata` one cycle after the address is presented.

Top module: `kbd_scanner`

## Requirements
- R1: After reset, all row lines are low, `irq_o` is low, and every register reads as zero.
- R2: Once enabled, the block waits 5 cycles, then drives rows 0 to ROWS-1 in ascending order. Exactly one row line is high at a time. Each row stays high for 16 plus the debounce count cycles. Then the idle gap register's number of cycles elapses with all rows low, and the sequence repeats.
- R3: The control register fields are: bit 0 enable, bit 1 keypress interrupt enable, bit 3 window interrupt enable, bits 13:4 the debounce count (0 to 0x3FF), bits 17:14 the threshold. All other bits read as zero.
- R4: The block counts consecutive sweeps in which a key was seen pressed, saturating at 1023. A key is held in a sweep when it reads pressed and this count has reached the debounce count. A debounce count of 0 qualifies a key on its first sighting.
- R5: At the end of each sweep, the window holds the first eight held keys in row-then-column order. Entry i sits in bits 8*(i mod 4)+7 down to 8*(i mod 4) of register 2 for i<4, and of register 3 for i≥4. Each entry has bit 7 set, the row in bits 6:3 and the column in bits 2:0. Unused entries are zero. The window changes at no other time while enabled.
- R6: Interrupt register bits 7:4 give the entry count. Bit 2 sets at the end of a sweep whose count is at or above the threshold, provided the window interrupt is enabled.
- R7: Bit 0 of the interrupt register sets when the sampled row shows a pressed column whose mask bit is 0, provided the keypress interrupt is enabled. Setting mask bit c of row r stops column c on row r from doing so.
- R8: Writing ones to bits 0 and 2 of the interrupt register clears those bits. When a clear and a set meet in the same cycle, the set wins. `irq_o` is high exactly when either status bit is set.
- R9: Clearing the enable bit drops all rows low on the next cycle. It also empties the window and zeroes the count, and it forgets the debounce history.
- R10: `reg_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| row_o | output | ROWS | Row drive, active high, at most one high |
| col_i | input | COLS | Column sense, active high when pressed |
| irq_o | output | 1 | Either interrupt status set |

## Verification
A wrong sweep counter or row index shows on `row_o` on the very cycle it goes wrong, because the bench compares the row lines with its model on every clock. A corrupted debounce history or entry builder does not appear until the next sweep ends. It then shows as a different window or count at the next read, and usually as an interrupt edge one sweep early or late. A status bit that misses its set or clear shows on `irq_o` on the following cycle.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int LEAD_CYC   = 5;
  localparam int ROW_BASE   = 16;
  localparam int DB_W       = 10;
  localparam int THR_W      = 4;
  localparam int RPT_W      = 16;
  localparam int CNT_W      = 17;
  localparam int ENT_MAX    = 8;
  localparam int ENT_IDX_W  = 3;
  localparam int ENT_CNT_W  = 4;
  localparam int BYTE_W     = 8;

  localparam int A_CTRL  = 0;
  localparam int A_INTR  = 1;
  localparam int A_ENT0  = 2;
  localparam int A_ENT1  = 3;
  localparam int A_RPT   = 4;
  localparam int A_MASK0 = 16;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_KPIE    = 1;
  localparam int CTRL_FIFOIE  = 3;
  localparam int CTRL_DB_LSB  = 4;
  localparam int CTRL_THR_LSB = 14;
  localparam logic [31:0] CTRL_WMASK = 32'h0003_FFFB;

  localparam int INTR_KP      = 0;
  localparam int INTR_FIFO    = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_ROW, ST_GAP} scan_st_t;
endpackage

// File: rtl/kbd_scan_timer.sv
module kbd_scan_timer
  import kbd_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [DB_W-1:0]         db,
  input  logic [RPT_W-1:0]        rpt,
  output logic [ROWS-1:0]         row_o,
  output logic [$clog2(ROWS)-1:0] row_idx,
  output logic                    sample,
  output logic                    last_row
);
  localparam int RIW = $clog2(ROWS);

  scan_st_t st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [RIW-1:0]   row_n;
  logic [CNT_W-1:0] row_last;
  logic             row_end;

  assign row_last = CNT_W'(ROW_BASE) + CNT_W'(db) - CNT_W'(1);
  assign row_end  = (st == ST_ROW) && (cnt >= row_last);
  assign sample   = en && row_end;
  assign last_row = (row_idx == RIW'(ROWS - 1));

  always_comb begin
    st_n  = st;
    cnt_n = cnt + CNT_W'(1);
    row_n = row_idx;
    if (!en) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      row_n = '0;
    end else begin
      case (st)
        ST_IDLE: begin
          st_n  = ST_LEAD;
          cnt_n = '0;
        end
        ST_LEAD: begin
          if (cnt >= CNT_W'(LEAD_CYC - 1)) begin
            st_n  = ST_ROW;
            cnt_n = '0;
            row_n = '0;
          end
        end
        ST_ROW: begin
          if (row_end) begin
            cnt_n = '0;
            if (last_row) begin
              row_n = '0;
              st_n  = (rpt == '0) ? ST_LEAD : ST_GAP;
            end else begin
              row_n = row_idx + RIW'(1);
            end
          end
        end
        ST_GAP: begin
          if (cnt + CNT_W'(1) >= CNT_W'(rpt)) begin
            st_n  = ST_LEAD;
            cnt_n = '0;
          end
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      row_idx <= '0;
      row_o   <= '0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      row_idx <= row_n;
      row_o   <= (st_n == ST_ROW) ? (ROWS'(1) << row_n) : '0;
    end
  end
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce
  import kbd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [DB_W-1:0]         db,
  input  logic [$clog2(ROWS)-1:0] row_idx,
  input  logic                    sample,
  input  logic [COLS-1:0]         col_in,
  output logic [COLS-1:0]         qual
);
  localparam int HW = DB_W;
  localparam int WW = COLS * HW;

  logic [WW-1:0]   hist_mem [ROWS];
  logic [WW-1:0]   rd_q;
  logic [WW-1:0]   wr_word;
  logic [ROWS-1:0] fresh;
  logic            row_fresh;

  assign row_fresh = fresh[row_idx];

  // one wide word per row: a whole row of histories is read and written at once
  always_ff @(posedge clk) begin
    if (sample) hist_mem[row_idx] <= wr_word;
    rd_q <= hist_mem[row_idx];
  end

  // rows not yet written since enable count as having no history
  always_ff @(posedge clk) begin
    if (rst || !en) fresh <= '0;
    else if (sample) fresh[row_idx] <= 1'b1;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [HW-1:0] old_h, bump_h, new_h;
    assign old_h  = row_fresh ? rd_q[c*HW +: HW] : '0;
    assign bump_h = (old_h == {HW{1'b1}}) ? old_h : old_h + HW'(1);
    assign new_h  = col_in[c] ? bump_h : '0;
    assign wr_word[c*HW +: HW] = new_h;
    assign qual[c] = col_in[c] && (new_h >= db);
  end
endmodule

// File: rtl/kbd_entry_list.sv
module kbd_entry_list
  import kbd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      sample,
  input  logic                      last_row,
  input  logic [$clog2(ROWS)-1:0]   row_idx,
  input  logic [COLS-1:0]           qual,
  output logic [ENT_MAX*BYTE_W-1:0] ent_flat,
  output logic [ENT_CNT_W-1:0]      ent_cnt,
  output logic [ENT_CNT_W-1:0]      pub_cnt
);
  logic [BYTE_W-1:0]    bld [ENT_MAX];
  logic [BYTE_W-1:0]    nb  [ENT_MAX];
  logic [BYTE_W-1:0]    ent [ENT_MAX];
  logic [ENT_CNT_W-1:0] bld_n, nn;

  always_comb begin
    for (int i = 0; i < ENT_MAX; i++) nb[i] = bld[i];
    nn = bld_n;
    for (int c = 0; c < COLS; c++) begin
      if (qual[c] && (nn < ENT_CNT_W'(ENT_MAX))) begin
        nb[nn[ENT_IDX_W-1:0]] = {1'b1, 4'(row_idx), 3'(c)};
        nn = nn + ENT_CNT_W'(1);
      end
    end
  end

  assign pub_cnt = nn;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      for (int i = 0; i < ENT_MAX; i++) begin
        bld[i] <= '0;
        ent[i] <= '0;
      end
      bld_n   <= '0;
      ent_cnt <= '0;
    end else if (sample) begin
      if (last_row) begin
        for (int i = 0; i < ENT_MAX; i++) begin
          ent[i] <= nb[i];
          bld[i] <= '0;
        end
        ent_cnt <= nn;
        bld_n   <= '0;
      end else begin
        for (int i = 0; i < ENT_MAX; i++) bld[i] <= nb[i];
        bld_n <= nn;
      end
    end
  end

  for (genvar i = 0; i < ENT_MAX; i++) begin : g_flat
    assign ent_flat[i*BYTE_W +: BYTE_W] = ent[i];
  end
endmodule

// File: rtl/kbd_scanner.sv
module kbd_scanner
  import kbd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [ROWS-1:0] row_o,
  input  logic [COLS-1:0] col_i,
  output logic            irq_o
);
  localparam int RIW = $clog2(ROWS);

  logic [31:0]          ctrl_q;
  logic [RPT_W-1:0]     rpt_q;
  logic [COLS-1:0]      mask_q [ROWS];
  logic                 kp_st, fifo_st, kp_n, fifo_n;
  logic                 en, kp_ie, fifo_ie;
  logic [DB_W-1:0]      db;
  logic [THR_W-1:0]     thr;
  logic [RIW-1:0]       row_idx;
  logic                 sample, last_row;
  logic [COLS-1:0]      qual;
  logic [ENT_MAX*BYTE_W-1:0] ent_flat;
  logic [ENT_CNT_W-1:0] ent_cnt, pub_cnt;
  logic                 kp_set, fifo_set, intr_wr;
  logic [31:0]          rd_word;

  assign en      = ctrl_q[CTRL_EN];
  assign kp_ie   = ctrl_q[CTRL_KPIE];
  assign fifo_ie = ctrl_q[CTRL_FIFOIE];
  assign db      = ctrl_q[CTRL_DB_LSB +: DB_W];
  assign thr     = ctrl_q[CTRL_THR_LSB +: THR_W];

  kbd_scan_timer #(.ROWS(ROWS)) u_timer (
    .clk(clk), .rst(rst), .en(en), .db(db), .rpt(rpt_q),
    .row_o(row_o), .row_idx(row_idx), .sample(sample), .last_row(last_row)
  );

  kbd_debounce #(.ROWS(ROWS), .COLS(COLS)) u_deb (
    .clk(clk), .rst(rst), .en(en), .db(db), .row_idx(row_idx),
    .sample(sample), .col_in(col_i), .qual(qual)
  );

  kbd_entry_list #(.ROWS(ROWS), .COLS(COLS)) u_list (
    .clk(clk), .rst(rst), .en(en), .sample(sample), .last_row(last_row),
    .row_idx(row_idx), .qual(qual), .ent_flat(ent_flat),
    .ent_cnt(ent_cnt), .pub_cnt(pub_cnt)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rpt_q  <= '0;
      for (int r = 0; r < ROWS; r++) mask_q[r] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(A_CTRL)) ctrl_q <= reg_wdata & CTRL_WMASK;
      if (reg_addr == AW'(A_RPT))  rpt_q  <= reg_wdata[RPT_W-1:0];
      for (int r = 0; r < ROWS; r++)
        if (reg_addr == AW'(A_MASK0 + r)) mask_q[r] <= reg_wdata[COLS-1:0];
    end
  end

  // sticky status: set has priority over write-one-to-clear
  assign intr_wr  = reg_wr && (reg_addr == AW'(A_INTR));
  assign kp_set   = sample && kp_ie && |(col_i & ~mask_q[row_idx]);
  assign fifo_set = sample && last_row && fifo_ie && (pub_cnt >= ENT_CNT_W'(thr));
  assign kp_n     = kp_set   || (kp_st   && !(intr_wr && reg_wdata[INTR_KP]));
  assign fifo_n   = fifo_set || (fifo_st && !(intr_wr && reg_wdata[INTR_FIFO]));

  always_ff @(posedge clk) begin
    if (rst) begin
      kp_st   <= 1'b0;
      fifo_st <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      kp_st   <= kp_n;
      fifo_st <= fifo_n;
      irq_o   <= kp_n || fifo_n;
    end
  end

  // read mux
  always_comb begin
    rd_word = '0;
    case (reg_addr)
      AW'(A_CTRL): rd_word = ctrl_q;
      AW'(A_INTR): rd_word = {24'h0, ent_cnt, 1'b0, fifo_st, 1'b0, kp_st};
      AW'(A_ENT0): rd_word = ent_flat[31:0];
      AW'(A_ENT1): rd_word = ent_flat[63:32];
      AW'(A_RPT):  rd_word = {{(32-RPT_W){1'b0}}, rpt_q};
      default: begin
        for (int r = 0; r < ROWS; r++)
          if (reg_addr == AW'(A_MASK0 + r)) rd_word = {{(32-COLS){1'b0}}, mask_q[r]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_word;
  end
endmodule

// File: rtl/kbd_scanner_sva.sv
module kbd_scanner_sva #(
  parameter int ROWS = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [ROWS-1:0] row_o,
  input logic            irq_o,
  input logic            en,
  input logic            kp_ie,
  input logic            fifo_ie,
  input logic            kp_st,
  input logic            fifo_st,
  input logic            sample,
  input logic [3:0]      ent_cnt
);
  p_one_row_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_o));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (row_o == '0 && ent_cnt == 4'd0));

  p_count_cap_r5: assert property (@(posedge clk) disable iff (rst)
    ent_cnt <= 4'd8);

  p_window_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !sample) |=> (ent_cnt == $past(ent_cnt)));

  p_fifo_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_st) |-> $past(fifo_ie));

  p_kp_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(kp_st) |-> $past(kp_ie));

  p_irq_or_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (kp_st || fifo_st));
endmodule

bind kbd_scanner kbd_scanner_sva #(.ROWS(ROWS)) u_sva (
  .clk(clk), .rst(rst), .row_o(row_o), .irq_o(irq_o), .en(en),
  .kp_ie(kp_ie), .fifo_ie(fifo_ie), .kp_st(kp_st), .fifo_st(fifo_st),
  .sample(sample), .ent_cnt(ent_cnt)
);

// File: tb/kbd_scanner_test.sv
module kbd_scanner_test;
  localparam int CLK_P = 10;
  localparam int ROWS  = 16;
  localparam int COLS  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [ROWS-1:0] row_o;
  logic [COLS-1:0] col_i;
  logic        irq_o;
  logic [COLS-1:0] keys [ROWS];

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  kbd_scanner uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .row_o(row_o),
    .col_i(col_i), .irq_o(irq_o)
  );

  // key matrix: a pressed key connects its row line to its column line
  always_comb begin
    col_i = '0;
    for (int r = 0; r < ROWS; r++) if (row_o[r]) col_i = col_i | keys[r];
  end

  // ---------------- reference model ----------------
  int m_en, m_kpie, m_fie, m_db, m_thr, m_rpt;
  int m_mask [ROWS];
  int m_ph, m_cnt, m_row;
  int m_hist [ROWS][COLS];
  logic [7:0] m_bld [$];
  logic [7:0] m_ent [8];
  int m_n, m_kst, m_fst, m_irq;
  int rowtime, samp, kset, fset, anyp;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_kpie = 0; m_fie = 0; m_db = 0; m_thr = 0; m_rpt = 0;
      for (int r = 0; r < ROWS; r++) begin
        m_mask[r] = 0;
        for (int c = 0; c < COLS; c++) m_hist[r][c] = 0;
      end
      m_ph = 0; m_cnt = 0; m_row = 0;
      m_bld.delete();
      for (int i = 0; i < 8; i++) m_ent[i] = 0;
      m_n = 0; m_kst = 0; m_fst = 0; m_irq = 0;
    end else begin
      rowtime = 16 + m_db;
      samp = (m_en != 0) && (m_ph == 2) && (m_cnt >= rowtime - 1);
      kset = 0; fset = 0;
      if (samp) begin
        anyp = 0;
        for (int c = 0; c < COLS; c++) begin
          if (keys[m_row][c]) begin
            if (m_hist[m_row][c] < 1023) m_hist[m_row][c]++;
            if (m_hist[m_row][c] >= m_db && m_bld.size() < 8)
              m_bld.push_back({1'b1, 4'(m_row), 3'(c)});
            if (((m_mask[m_row] >> c) & 1) == 0) anyp = 1;
          end else begin
            m_hist[m_row][c] = 0;
          end
        end
        if (anyp && m_kpie) kset = 1;
        if (m_row == ROWS - 1) begin
          for (int i = 0; i < 8; i++) m_ent[i] = (i < m_bld.size()) ? m_bld[i] : 8'h00;
          m_n = m_bld.size();
          if (m_fie && m_n >= m_thr) fset = 1;
          m_bld.delete();
        end
      end
      if (!m_en) begin
        m_bld.delete();
        for (int i = 0; i < 8; i++) m_ent[i] = 0;
        m_n = 0;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++) m_hist[r][c] = 0;
      end
      // sweep sequencing
      if (!m_en) begin
        m_ph = 0; m_cnt = 0; m_row = 0;
      end else begin
        case (m_ph)
          0: begin m_ph = 1; m_cnt = 0; end
          1: if (m_cnt >= 4) begin m_ph = 2; m_cnt = 0; m_row = 0; end else m_cnt++;
          2: if (m_cnt >= rowtime - 1) begin
               m_cnt = 0;
               if (m_row == ROWS - 1) begin m_row = 0; m_ph = (m_rpt == 0) ? 1 : 3; end
               else m_row++;
             end else m_cnt++;
          default: if (m_cnt + 1 >= m_rpt) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
        endcase
      end
      if (reg_wr && reg_addr == 5'd1) begin
        if (reg_wdata[0]) m_kst = 0;
        if (reg_wdata[2]) m_fst = 0;
      end
      if (kset) m_kst = 1;
      if (fset) m_fst = 1;
      if (reg_wr) begin
        if (reg_addr == 5'd0) begin
          m_en = reg_wdata[0]; m_kpie = reg_wdata[1]; m_fie = reg_wdata[3];
          m_db = int'(reg_wdata[13:4]); m_thr = int'(reg_wdata[17:14]);
        end
        if (reg_addr == 5'd4) m_rpt = int'(reg_wdata[15:0]);
        if (reg_addr >= 5'd16) m_mask[reg_addr - 5'd16] = int'(reg_wdata[7:0]);
      end
      m_irq = m_kst | m_fst;
    end
  end

  function automatic logic [31:0] model_reg(int a);
    logic [31:0] v;
    v = '0;
    case (a)
      0: v = 32'(m_thr << 14) | 32'(m_db << 4) | 32'(m_fie << 3) | 32'(m_kpie << 1) | 32'(m_en);
      1: v = 32'(m_n << 4) | 32'(m_fst << 2) | 32'(m_kst);
      2: v = {m_ent[3], m_ent[2], m_ent[1], m_ent[0]};
      3: v = {m_ent[7], m_ent[6], m_ent[5], m_ent[4]};
      4: v = 32'(m_rpt);
      default: if (a >= 16 && a < 16 + ROWS) v = 32'(m_mask[a - 16]);
    endcase
    return v;
  endfunction

  // ---------------- per-cycle comparison ----------------
  logic [ROWS-1:0] exp_row;
  always @(negedge clk) begin
    if (!rst) begin
      exp_row = (m_ph == 2) ? (ROWS'(1) << m_row) : '0;
      total++;
      if (row_o !== exp_row) begin
        bad++;
        $display("FAIL R2 row drive: actual=%h expected=%h t=%0t", row_o, exp_row, $time);
      end
      total++;
      if (irq_o !== m_irq[0]) begin
        bad++;
        $display("FAIL R8 irq: actual=%b expected=%b t=%0t", irq_o, m_irq[0], $time);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = 5'(a);
    e = model_reg(a);
    @(negedge clk);
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s addr=%0d: actual=%h expected=%h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    rd(0, "R1 ctrl"); rd(1, "R1 intr"); rd(2, "R1 ent0");
    rd(3, "R1 ent1"); rd(4, "R1 rpt"); rd(21, "R1 mask");

    // R3 / R10: control layout and readback; db=2, thr=2, gap=3
    wr(4, 32'd3);
    rd(4, "R10 rpt readback");
    keys[3] = 8'b0010_0010;
    keys[10] = 8'b0000_0001;
    wr(0, 32'h0000_802B);
    rd(0, "R3 ctrl fields");
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R3 reserved bits zero");
    wr(0, 32'h0000_802B);

    // R4: after one sweep the history is below the debounce count
    run(320);
    rd(1, "R4 count after first sweep");
    run(600);
    rd(1, "R6 count and window status");
    rd(2, "R5 entries 0-3");
    rd(3, "R5 entries 4-7");

    // R8: write-one-to-clear
    wr(1, 32'h5);
    rd(1, "R8 cleared status");

    // R5: more than eight held keys keeps the first eight in scan order
    keys[12] = 8'hFF;
    keys[13] = 8'h03;
    run(900);
    rd(1, "R5 count capped");
    rd(2, "R5 overflow entries 0-3");
    rd(3, "R5 overflow entries 4-7");

    // R6: release everything, count below threshold leaves window status clear
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
    run(400);
    wr(1, 32'h5);
    run(700);
    rd(1, "R6 below threshold");
    rd(2, "R5 empty window");

    // R7: masked rows ignore presses for the keypress source
    for (int r = 0; r < ROWS; r++) wr(16 + r, 32'hFF);
    rd(21, "R7 mask readback");
    wr(1, 32'h5);
    keys[5] = 8'b0000_0100;
    run(700);
    rd(1, "R7 masked keypress ignored");
    wr(21, 32'hFB);
    run(400);
    rd(1, "R7 unmasked keypress sets");

    // R9: disable clears the window and stops the rows
    wr(0, 32'h0000_802A);
    run(5);
    rd(1, "R9 count cleared");
    rd(2, "R9 window cleared");

    // R4: debounce 0 and threshold 1 qualify on first sighting
    wr(1, 32'h5);
    wr(0, 32'h0000_4009);
    run(350);
    rd(1, "R4 zero debounce");
    rd(2, "R4 zero debounce entry");

    // R2: no gap between sweeps
    wr(4, 32'd0);
    run(700);
    rd(2, "R2 gapless sweep entry");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule